// File: doc/BRIEF.md
# Four-Bit General-Purpose I/O Port

This block is a small general-purpose I/O port with four pins. A host reaches it over a simple synchronous register bus that carries an address, a write strobe, a read strobe, write data and read data. Two byte-wide registers sit on that bus. The direction register selects, pin by pin, whether a pin drives or listens. The data register holds the output latch.

Each pin also has a general-I/O enable from the surrounding pin-function logic. A pin is driven only when it is set as an output and that enable is high. Otherwise its output enable is low, so the pad is left in high impedance. The pin output value always follows the latch.

A read of the data register mixes two sources bit by bit. Bits of output pins return the latch. Bits of input pins return the pin level after a two-flop synchronizer. The upper four bits always read as ones. The direction register cannot be read back and returns all ones. Read data is registered and keeps its value between reads.

Top module: `gpio4_port`

## Requirements
- R1: While reset is high, and on the first clock after it, `pin_out`, `pin_oe` and `bus_rdata` are all zero: latch 0000, every pin an input.
- R2: A write to address 0xFFED loads write-data bits 3..0 into the direction register on that clock edge. A bit value of 1 means output and 0 means input. `pin_oe[n]` equals direction bit n AND `pin_gpio_en[n]`.
- R3: A write to address 0xFFDD loads write-data bits 3..0 into the output latch, even for pins that are currently inputs. `pin_out` equals the latch from the next cycle on.
- R4: A data-register read returns the latch value in each bit n whose direction bit is 1.
- R5: A data-register read returns the synchronized pin level in each bit n whose direction bit is 0. A pin change applied before clock edge k is first visible to a read strobed at edge k+2.
- R6: Bits 7..4 of a data-register read are always 1, and writes to those bits have no effect.
- R7: Any read of the direction register returns 0xFF.
- R8: A read of any address other than 0xFFDD or 0xFFED returns 0x00. A write to such an address changes neither the latch nor the direction bits.
- R9: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low. A read and a write in the same cycle return the pre-write state.
- R10: `pin_oe[n]` is 0 whenever `pin_gpio_en[n]` is 0, whatever the direction bit. The read-back selection still follows the direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 4 | Pad input levels |
| pin_gpio_en | input | 4 | Per-pin general-I/O function enable |
| pin_out | output | 4 | Pad output values (output latch) |
| pin_oe | output | 4 | Pad output enables; 0 leaves the pad in high impedance |

## Verification
Most internal state in this port can be observed at the pins. A wrong latch bit shows on `pin_out` one cycle after the write. A wrong direction bit shows on `pin_oe` in that same cycle for any enabled pin. A wrong direction bit on a disabled pin stays hidden until a data-register read, which then picks the wrong source for that bit. A synchronizer with too few or too many stages cannot be seen on the pins. It shows up only as a read that returns the new pin level one cycle early or late, so the bench changes pin levels right next to read strobes.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs #(
  parameter int PIN_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_latch,
  input  logic             wr_dir,
  input  logic [PIN_N-1:0] wbits,
  output logic [PIN_N-1:0] latch_q,
  output logic [PIN_N-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wbits;
      if (wr_dir)   dir_q   <= wbits;
    end
  end
endmodule

// File: rtl/gpio4_readmux.sv
module gpio4_readmux
  import gpio4_pkg::*;
#(
  parameter int PIN_N  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [PIN_N-1:0]  latch_q,
  input  logic [PIN_N-1:0]  dir_q,
  input  logic [PIN_N-1:0]  pin_sync,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - PIN_N;

  logic [PIN_N-1:0]  mixed;
  logic [DATA_W-1:0] next_rdata;

  generate
    for (genvar n = 0; n < PIN_N; n++) begin : g_bit
      assign mixed[n] = dir_q[n] ? latch_q[n] : pin_sync[n];
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_DATA: next_rdata = {{PAD_W{1'b1}}, mixed};
      SEL_DIR:  next_rdata = '1;
      default:  next_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= next_rdata;
  end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              PIN_N       = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFDD,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_N-1:0]  pin_in,
  input  logic [PIN_N-1:0]  pin_gpio_en,
  output logic [PIN_N-1:0]  pin_out,
  output logic [PIN_N-1:0]  pin_oe
);
  reg_sel_e         sel;
  logic [PIN_N-1:0] latch_q;
  logic [PIN_N-1:0] dir_q;
  logic [PIN_N-1:0] pin_sync;

  always_comb begin
    if (bus_addr == DATA_ADDR)     sel = SEL_DATA;
    else if (bus_addr == DIR_ADDR) sel = SEL_DIR;
    else                           sel = SEL_NONE;
  end

  gpio4_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio4_regs #(.PIN_N(PIN_N)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_latch (bus_wr && sel == SEL_DATA),
    .wr_dir   (bus_wr && sel == SEL_DIR),
    .wbits    (bus_wdata[PIN_N-1:0]),
    .latch_q  (latch_q),
    .dir_q    (dir_q)
  );

  gpio4_readmux #(.PIN_N(PIN_N), .DATA_W(DATA_W)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .sel      (sel),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q & pin_gpio_en;
endmodule

// File: rtl/gpio4_port_chk.sv
module gpio4_port_chk #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              PIN_N     = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFDD,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFED
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PIN_N-1:0]  pin_gpio_en,
  input logic [PIN_N-1:0]  pin_out,
  input logic [PIN_N-1:0]  pin_oe
);
  localparam int PAD_W = DATA_W - PIN_N;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == DATA_ADDR) |=> pin_out == $past(bus_wdata[PIN_N-1:0]));

  // R6
  upper_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == DATA_ADDR) |=> bus_rdata[DATA_W-1:PIN_N] == {PAD_W{1'b1}});

  // R7
  dir_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == DIR_ADDR) |=> bus_rdata == {DATA_W{1'b1}});

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != DATA_ADDR && bus_addr != DIR_ADDR) |=> bus_rdata == '0);

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != DATA_ADDR && bus_addr != DIR_ADDR) |=> $stable(pin_out));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R10
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~pin_gpio_en) == '0);
endmodule

bind gpio4_port gpio4_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_N(PIN_N),
  .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_gpio_en(pin_gpio_en),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_gpio4_port.sv
`timescale 1ns/1ps
module sim_gpio4_port;
  localparam logic [15:0] A_DATA = 16'hFFDD;
  localparam logic [15:0] A_DIR  = 16'hFFED;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_gpio_en = '0;
  logic [3:0]  pin_out;
  logic [3:0]  pin_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  gpio4_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_gpio_en(pin_gpio_en), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // Behavioural reference: pin history queue, plain variables for the registers
  logic [3:0] m_latch = '0;
  logic [3:0] m_dir   = '0;
  logic [7:0] m_rdata = '0;
  logic [3:0] hist[$] = '{4'h0, 4'h0};
  string      m_tag   = "R1";
  bit         post_rst = 1'b1;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_latch = '0; m_dir = '0; m_rdata = '0;
      hist = '{4'h0, 4'h0};
      m_tag = "R1"; post_rst = 1'b1;
    end else begin
      logic [3:0] seen;
      seen = hist[hist.size()-2];
      if (bus_rd) begin
        if (bus_addr == A_DATA) begin
          for (int n = 0; n < 4; n++) m_rdata[n] = m_dir[n] ? m_latch[n] : seen[n];
          m_rdata[7:4] = 4'hF;
          m_tag = "R4 R5 R6 R9";
        end else if (bus_addr == A_DIR) begin
          m_rdata = 8'hFF; m_tag = "R7";
        end else begin
          m_rdata = 8'h00; m_tag = "R8";
        end
      end else if (!post_rst) m_tag = "R9";
      if (bus_wr && bus_addr == A_DATA) m_latch = bus_wdata[3:0];
      if (bus_wr && bus_addr == A_DIR)  m_dir   = bus_wdata[3:0];
      hist.push_back(pin_in);
      void'(hist.pop_front());
      post_rst = 1'b0;
    end
    #3;
    chk({m_tag, " rdata"}, bus_rdata, m_rdata);
    chk(post_rst ? "R1 pin_out" : "R3 R8 pin_out", {4'h0, pin_out}, {4'h0, m_latch});
    chk(post_rst ? "R1 pin_oe" : "R2 R10 pin_oe", {4'h0, pin_oe}, {4'h0, m_dir & pin_gpio_en});
  end

  task automatic step();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pin_gpio_en = 4'hF;
    // R2 R3 R4 R6: outputs read back the latch
    wr(A_DIR, 8'h0F);
    wr(A_DATA, 8'hA5);
    rd(A_DATA);
    step();
    #1 chk("R4 R6 explicit", bus_rdata, 8'hF5);
    // R7
    rd(A_DIR);
    step();
    #1 chk("R7 explicit", bus_rdata, 8'hFF);
    // R5 mixed read with R10 gating
    pin_in = 4'hA;
    wr(A_DIR, 8'h03);
    pin_gpio_en = 4'h5;
    step(); step();
    rd(A_DATA);
    step();
    #1 chk("R5 explicit", bus_rdata, 8'hF9);
    #1 chk("R10 explicit", {4'h0, pin_oe}, 8'h01);
    // R5 timing: change right before a read strobe
    pin_in = 4'h5;
    rd(A_DATA); rd(A_DATA); rd(A_DATA);
    step();
    // R8 unmapped write and read
    wr(16'h1234, 8'hFF);
    rd(16'h0000);
    step();
    #1 chk("R8 explicit", bus_rdata, 8'h00);
    #1 chk("R8 latch kept", {4'h0, pin_out}, 8'h05);
    // R3 write while input, then switch to output
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h06);
    pin_gpio_en = 4'hF;
    wr(A_DIR, 8'h0F);
    step();
    #1 chk("R3 explicit", {4'h0, pin_oe & pin_out}, 8'h06);
    // R9 simultaneous read and write
    @(negedge clk);
    bus_addr = A_DATA; bus_wdata = 8'h09; bus_wr = 1'b1; bus_rd = 1'b1;
    step();
    #1 chk("R9 explicit", bus_rdata, 8'hF6);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      case ($urandom_range(0, 3))
        0: bus_addr = A_DATA;
        1: bus_addr = A_DIR;
        2: bus_addr = A_DATA;
        default: bus_addr = 16'($urandom);
      endcase
      bus_wr = 1'($urandom); bus_rd = 1'($urandom);
      bus_wdata = 8'($urandom);
      pin_in = 4'($urandom);
      pin_gpio_en = 4'($urandom);
    end
    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    step(); rst = 1'b0;
    step(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; fails++;
    $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule